// File: doc/BRIEF.md
# Inbound Mailbox Circular Frame Queue

This block decides where a message receiver places each incoming message in memory. The messages land in a circular ring of equal-sized frames. The ring starts at a base address that is aligned to the ring's total size. The block holds the write (enqueue) pointer, and software owns and advances the read (dequeue) pointer. For every accepted message the block issues one frame write to the current write address. When the memory side reports completion, the write pointer moves ahead by one frame. If it moves past the last frame, it wraps back to the start of the ring.

Two events are flagged: the ring becoming full, and an empty ring receiving its first message. Each sets a sticky status bit when its enable is on, and the enabled status bits drive one interrupt line. While the ring is full, arriving messages are refused with a retry indication until software frees a frame by moving the read pointer. The ring depth and the frame size each come from a 4-bit configuration code. The write pointer can only be loaded while the controller is disabled.

Top module: `inbound_frame_queue`

## Requirements
- R1: When `msg_req` is accepted, `mem_req` rises with `mem_addr` equal to the write pointer. Both hold until `mem_done`. `msg_ack` is high in the cycle where `mem_req` and `mem_done` are both high.
- R2: On the clock edge that completes a write, the write pointer (`enq_ptr`) advances by one frame size.
- R3: The advance changes only the low log2(depth × frame size) address bits. Moving past the last frame wraps to the ring base, and the upper bits are kept.
- R4: If the write pointer equals the read pointer after an advance, the ring is full. While full, `msg_req` is answered by `msg_retry` in the same cycle, and no `mem_req` is issued.
- R5: On entering full, `status[1]` is set only if `full_ie` is 1.
- R6: If the two pointers were equal and the ring was not full just before an advance, `status[0]` is set, only if `msg_ie` is 1. It is not set when the pointers differed.
- R7: Status bits are write-one-to-clear through `sts_clr_wr` with `sts_clr_data` (bit 0 clears status[0], bit 1 clears status[1]). `irq` = (status[0] & msg_ie) | (status[1] & full_ie).
- R8: A read-pointer write that makes the two pointers differ clears the full condition, and messages are accepted again.
- R9: A write-pointer write takes effect only while `enable` is 0 and is ignored while `enable` is 1. Bits 2..0 of both pointers read as zero.
- R10: Depth code N selects 2^(N+1) entries, and N > 10 behaves as 2048. Frame code M selects 2^(M+3) bytes, and M > 9 behaves as 4096.
- R11: While `enable` is 0, `msg_req` gets neither `msg_ack` nor `msg_retry`, and no write is issued.
- R12: After reset, `enq_ptr` is 0, `status` is 0, `irq` is 0 and `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enable |
| depth_sel | input | 4 | Ring depth code |
| frame_sel | input | 4 | Frame size code |
| full_ie | input | 1 | Full interrupt enable |
| msg_ie | input | 1 | Message-in-queue interrupt enable |
| enq_wr | input | 1 | Write-pointer load strobe |
| enq_wr_data | input | 32 | Write-pointer load value |
| deq_wr | input | 1 | Read-pointer write strobe |
| deq_wr_data | input | 32 | Read-pointer write value |
| msg_req | input | 1 | Message arrival request, held until ack or retry |
| msg_ack | output | 1 | Message stored |
| msg_retry | output | 1 | Message refused, ring full |
| mem_req | output | 1 | Frame write request |
| mem_addr | output | 32 | Frame write address |
| mem_done | input | 1 | Frame write completion |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_data | input | 2 | Status bits to clear |
| enq_ptr | output | 32 | Current write pointer |
| status | output | 2 | {full, message-in-queue} sticky status |
| irq | output | 1 | Interrupt |

## Verification
The bench fills an 8-frame ring until the write pointer wraps onto the read pointer. A design that dropped the upper address bits, or wrapped at the wrong boundary, would store into the wrong frame or would never detect full. It then checks that a full ring refuses messages, and that moving the read pointer re-opens it. A design that confused the empty and full cases would either accept into occupied frames or keep refusing after space was freed. The bench also tries a pointer load while the controller is enabled, sends messages with an interrupt enable cleared, and uses the smallest and the reserved depth and frame codes. Wrong gating would show up as a moved pointer, a spurious status bit, or a wrong frame stride.

// File: rtl/ifq_pkg.sv
// Shared definitions for the inbound frame queue.
// Assumes byte addresses and a reserved low field of fixed width.
package ifq_pkg;
    localparam int ADDR_W        = 32;
    localparam int SEL_W         = 4;
    localparam int RSV_LOW_BITS  = 3;   // pointer bits forced to zero
    localparam int MAX_DEPTH_SEL = 10;  // 2^(10+1) = 2048 entries
    localparam int MAX_FRAME_SEL = 9;   // 2^(9+3)  = 4096 bytes
    localparam int DEPTH_LOG_OFS = 1;
    localparam int FRAME_LOG_OFS = 3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } ifq_state_t;
endpackage

// File: rtl/ifq_geom.sv
// Ring geometry: decodes the depth and frame codes and computes the next
// write pointer, wrapping inside the ring region.
// Assumes the current pointer lies inside a region aligned to its size.
module ifq_geom
    import ifq_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int SW        = SEL_W,
    parameter int MAX_D_SEL = MAX_DEPTH_SEL,
    parameter int MAX_F_SEL = MAX_FRAME_SEL
) (
    input  logic [SW-1:0] depth_sel,
    input  logic [SW-1:0] frame_sel,
    input  logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] next_ptr
);
    localparam int LOG_W = $clog2(AW) + 1;

    logic [LOG_W-1:0] depth_log;
    logic [LOG_W-1:0] frame_log;
    logic [LOG_W-1:0] region_log;
    logic [AW-1:0]    frame_step;
    logic [AW-1:0]    region_mask;

    // Clamp reserved codes and turn them into log2 sizes.
    always_comb begin
        if (int'(depth_sel) > MAX_D_SEL) depth_log = LOG_W'(MAX_D_SEL + DEPTH_LOG_OFS);
        else                             depth_log = LOG_W'(depth_sel) + LOG_W'(DEPTH_LOG_OFS);
        if (int'(frame_sel) > MAX_F_SEL) frame_log = LOG_W'(MAX_F_SEL + FRAME_LOG_OFS);
        else                             frame_log = LOG_W'(frame_sel) + LOG_W'(FRAME_LOG_OFS);
        region_log = depth_log + frame_log;
    end

    // Step one frame and keep the bits above the region unchanged.
    always_comb begin
        frame_step  = AW'(1) << frame_log;
        region_mask = (AW'(1) << region_log) - AW'(1);
        next_ptr    = (cur_ptr & ~region_mask) | ((cur_ptr + frame_step) & region_mask);
    end
endmodule

// File: rtl/ifq_ptrs.sv
// Pointer registers: write pointer, read pointer and the full flag that
// tells an equal-pointer full ring from an empty one.
// Assumes software loads the write pointer only while disabled.
module ifq_ptrs
    import ifq_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int RSV = RSV_LOW_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          enq_wr,
    input  logic [AW-1:0] enq_wr_data,
    input  logic          deq_wr,
    input  logic [AW-1:0] deq_wr_data,
    input  logic          advance,
    input  logic [AW-1:0] next_ptr,
    output logic [AW-1:0] enq_ptr,
    output logic          full,
    output logic          was_empty,
    output logic          will_fill
);
    localparam logic [AW-1:0] KEEP_MASK = ~((AW'(1) << RSV) - AW'(1));

    logic [AW-1:0] deq_ptr;
    logic [AW-1:0] deq_new;
    logic [AW-1:0] enq_new;

    // Mask the reserved low bits off the incoming values.
    always_comb begin
        deq_new   = deq_wr_data & KEEP_MASK;
        enq_new   = enq_wr_data & KEEP_MASK;
        was_empty = (enq_ptr == deq_ptr) && !full;
        will_fill = (next_ptr == deq_ptr);
    end

    // Write pointer: hardware advance, or a load while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  enq_ptr <= '0;
        else if (advance)            enq_ptr <= next_ptr;
        else if (enq_wr && !enable)  enq_ptr <= enq_new;
    end

    // Read pointer: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)      deq_ptr <= '0;
        else if (deq_wr) deq_ptr <= deq_new;
    end

    // Full flag: set when an advance lands on the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)                                full <= 1'b0;
        else if (advance)                          full <= will_fill;
        else if (enq_wr && !enable)                full <= 1'b0;
        else if (deq_wr && (deq_new != enq_ptr))   full <= 1'b0;
    end
endmodule

// File: rtl/ifq_status.sv
// Sticky event status with write-one-to-clear and the interrupt merge.
// Assumes set events already carry their enable; a set wins over a clear.
module ifq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_msg,
    input  logic       set_full,
    input  logic       clr_wr,
    input  logic [1:0] clr_data,
    input  logic       msg_ie,
    input  logic       full_ie,
    output logic [1:0] status,
    output logic       irq
);
    // Hold each event bit until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            if (set_msg)                   status[0] <= 1'b1;
            else if (clr_wr && clr_data[0]) status[0] <= 1'b0;
            if (set_full)                  status[1] <= 1'b1;
            else if (clr_wr && clr_data[1]) status[1] <= 1'b0;
        end
    end

    // Merge the enabled status bits into one interrupt.
    always_comb irq = (status[0] & msg_ie) | (status[1] & full_ie);
endmodule

// File: rtl/inbound_frame_queue.sv
// Inbound mailbox frame queue: accepts message arrivals, writes each to
// the current ring frame, advances the write pointer and flags events.
// Assumes the sender holds msg_req until it sees msg_ack or msg_retry.
module inbound_frame_queue
    import ifq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic [SEL_W-1:0]  frame_sel,
    input  logic              full_ie,
    input  logic              msg_ie,
    input  logic              enq_wr,
    input  logic [ADDR_W-1:0] enq_wr_data,
    input  logic              deq_wr,
    input  logic [ADDR_W-1:0] deq_wr_data,
    input  logic              msg_req,
    output logic              msg_ack,
    output logic              msg_retry,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done,
    input  logic              sts_clr_wr,
    input  logic [1:0]        sts_clr_data,
    output logic [ADDR_W-1:0] enq_ptr,
    output logic [1:0]        status,
    output logic              irq
);
    ifq_state_t        state;
    logic              full;
    logic              was_empty;
    logic              will_fill;
    logic              accept;
    logic [ADDR_W-1:0] next_ptr;

    ifq_geom u_geom (
        .depth_sel (depth_sel),
        .frame_sel (frame_sel),
        .cur_ptr   (enq_ptr),
        .next_ptr  (next_ptr)
    );

    ifq_ptrs u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .enq_wr      (enq_wr),
        .enq_wr_data (enq_wr_data),
        .deq_wr      (deq_wr),
        .deq_wr_data (deq_wr_data),
        .advance     (msg_ack),
        .next_ptr    (next_ptr),
        .enq_ptr     (enq_ptr),
        .full        (full),
        .was_empty   (was_empty),
        .will_fill   (will_fill)
    );

    ifq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_msg  (msg_ack && msg_ie && was_empty),
        .set_full (msg_ack && full_ie && will_fill),
        .clr_wr   (sts_clr_wr),
        .clr_data (sts_clr_data),
        .msg_ie   (msg_ie),
        .full_ie  (full_ie),
        .status   (status),
        .irq      (irq)
    );

    // Arrival decode: accept into a free frame or refuse when full.
    always_comb begin
        accept    = (state == ST_IDLE) && msg_req && enable && !full;
        msg_retry = (state == ST_IDLE) && msg_req && enable && full;
        mem_req   = (state == ST_WRITE);
        mem_addr  = enq_ptr;
        msg_ack   = (state == ST_WRITE) && mem_done;
    end

    // Sequencer: one frame write in flight at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= ST_IDLE;
        else if (accept)  state <= ST_WRITE;
        else if (msg_ack) state <= ST_IDLE;
    end
endmodule

// File: rtl/ifq_checks.sv
// Property checker for inbound_frame_queue, attached by bind.
module ifq_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        enq_wr,
    input logic        msg_ack,
    input logic        msg_retry,
    input logic        mem_req,
    input logic        mem_done,
    input logic [31:0] mem_addr,
    input logic [31:0] enq_ptr,
    input logic [1:0]  status
);
    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr)));

    assert_ack_with_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ack |-> (mem_req && mem_done));

    assert_retry_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_retry |-> (!mem_req && !msg_ack));

    assert_full_sts_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(msg_ack));

    assert_msg_sts_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(msg_ack));

    assert_locked_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && enq_wr && !msg_ack) |=> $stable(enq_ptr));

    assert_quiet_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !mem_req) |-> (!msg_ack && !msg_retry));
endmodule

bind inbound_frame_queue ifq_checks u_ifq_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .enq_wr    (enq_wr),
    .msg_ack   (msg_ack),
    .msg_retry (msg_retry),
    .mem_req   (mem_req),
    .mem_done  (mem_done),
    .mem_addr  (mem_addr),
    .enq_ptr   (enq_ptr),
    .status    (status)
);

// File: tb/inbound_frame_queue_tb_top.sv
// Scoreboard bench: send_msg queues the expected frame address, the
// monitor pops it when a frame write completes and compares.
module inbound_frame_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  depth_sel = 4'd2;
    logic [3:0]  frame_sel = 4'd4;
    logic        full_ie = 1'b1;
    logic        msg_ie = 1'b1;
    logic        enq_wr = 1'b0;
    logic [31:0] enq_wr_data = '0;
    logic        deq_wr = 1'b0;
    logic [31:0] deq_wr_data = '0;
    logic        msg_req = 1'b0;
    logic        msg_ack;
    logic        msg_retry;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_done = 1'b0;
    logic        sts_clr_wr = 1'b0;
    logic [1:0]  sts_clr_data = '0;
    logic [31:0] enq_ptr;
    logic [1:0]  status;
    logic        irq;

    int          n_tests = 0;
    int          n_fail = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    inbound_frame_queue dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
        .frame_sel(frame_sel), .full_ie(full_ie), .msg_ie(msg_ie),
        .enq_wr(enq_wr), .enq_wr_data(enq_wr_data), .deq_wr(deq_wr),
        .deq_wr_data(deq_wr_data), .msg_req(msg_req), .msg_ack(msg_ack),
        .msg_retry(msg_retry), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_done(mem_done), .sts_clr_wr(sts_clr_wr), .sts_clr_data(sts_clr_data),
        .enq_ptr(enq_ptr), .status(status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_enq(input logic [31:0] d);
        @(negedge clk); enq_wr = 1'b1; enq_wr_data = d;
        @(negedge clk); enq_wr = 1'b0;
    endtask

    task automatic wr_deq(input logic [31:0] d);
        @(negedge clk); deq_wr = 1'b1; deq_wr_data = d;
        @(negedge clk); deq_wr = 1'b0;
    endtask

    task automatic clr_sts(input logic [1:0] d);
        @(negedge clk); sts_clr_wr = 1'b1; sts_clr_data = d;
        @(negedge clk); sts_clr_wr = 1'b0;
    endtask

    // Driver: one message, with the expected outcome pushed for the monitor.
    task automatic send_msg(input bit exp_retry, input logic [31:0] exp_addr,
                            input int lat, input string req);
        bit finished = 1'b0;
        bit got_retry = 1'b0;
        if (!exp_retry) exp_q.push_back(exp_addr);
        @(negedge clk); msg_req = 1'b1; #1;
        for (int i = 0; i < 20 && !finished; i++) begin
            if (msg_retry) begin
                got_retry = 1'b1; finished = 1'b1;
            end else if (mem_req) begin
                repeat (lat) @(negedge clk);
                #1 mem_done = 1'b1;
                @(negedge clk); mem_done = 1'b0; finished = 1'b1;
            end else begin
                @(negedge clk); #1;
            end
        end
        msg_req = 1'b0;
        check({req, " retry"}, 32'(got_retry), 32'(exp_retry));
        if (!finished) check({req, " completion"}, 32'd0, 32'd1);
    endtask

    // Monitor: compare each completed frame write with the scoreboard.
    initial begin
        forever begin
            @(negedge clk); #3;
            if (mem_req && mem_done) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected write", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check("R1 frame address", mem_addr, e);
                    check("R1 ack", 32'(msg_ack), 32'd1);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 enq_ptr reset", enq_ptr, 32'h0);
        check("R12 status reset", 32'(status), 32'h0);
        check("R12 irq reset", 32'(irq), 32'h0);
        check("R12 mem_req reset", 32'(mem_req), 32'h0);

        // Pointer load while disabled, reserved bits dropped.
        wr_enq(32'h0000_2C07);
        check("R9 load while disabled", enq_ptr, 32'h0000_2C00);
        wr_deq(32'h0000_2C00);

        // Disabled controller ignores arrivals.
        seen = 1'b0;
        @(negedge clk); msg_req = 1'b1;
        repeat (4) begin
            @(negedge clk); #1;
            if (msg_ack || msg_retry || mem_req) seen = 1'b1;
        end
        msg_req = 1'b0;
        check("R11 disabled ignores msg", 32'(seen), 32'd0);

        // 8 entries of 128 bytes at base 0x2C00.
        enable = 1'b1;
        send_msg(1'b0, 32'h0000_2C00, 2, "R1 first msg");
        check("R2 advance one frame", enq_ptr, 32'h0000_2C80);
        check("R6 msg status", 32'(status), 32'h1);
        check("R7 irq from msg", 32'(irq), 32'h1);
        clr_sts(2'b01);
        check("R7 W1C msg", 32'(status), 32'h0);
        check("R7 irq cleared", 32'(irq), 32'h0);

        wr_enq(32'h0000_5000);
        check("R9 load ignored when enabled", enq_ptr, 32'h0000_2C80);

        for (int k = 1; k < 8; k++)
            send_msg(1'b0, 32'h0000_2C00 + 32'(k) * 32'h80, k % 2, "R2 fill");
        check("R3 wrap to base", enq_ptr, 32'h0000_2C00);
        check("R5 full status", 32'(status), 32'h2);
        check("R7 irq from full", 32'(irq), 32'h1);

        send_msg(1'b1, 32'h0, 0, "R4 full retry");
        check("R4 ptr unchanged on retry", enq_ptr, 32'h0000_2C00);

        wr_deq(32'h0000_2C80);
        send_msg(1'b0, 32'h0000_2C00, 0, "R8 reopened");
        check("R6 no msg status when nonempty", 32'(status[0]), 32'h0);

        // Full interrupt enable off.
        full_ie = 1'b0;
        clr_sts(2'b11);
        wr_deq(32'h0000_2D00);
        send_msg(1'b0, 32'h0000_2C80, 1, "R8 reopened again");
        check("R5 full status gated", 32'(status[1]), 32'h0);
        check("R7 irq gated", 32'(irq), 32'h0);
        send_msg(1'b1, 32'h0, 0, "R4 full without status");
        full_ie = 1'b1;

        // Smallest codes: 2 entries of 8 bytes.
        enable = 1'b0;
        depth_sel = 4'd0; frame_sel = 4'd0;
        wr_enq(32'h0000_0040);
        wr_deq(32'h0000_0040);
        enable = 1'b1;
        send_msg(1'b0, 32'h0000_0040, 0, "R10 small first");
        check("R10 8-byte stride", enq_ptr, 32'h0000_0048);
        send_msg(1'b0, 32'h0000_0048, 0, "R10 small second");
        check("R3 16-byte wrap", enq_ptr, 32'h0000_0040);
        check("R5 small full", 32'(status[1]), 32'h1);

        // Reserved codes clamp to 2048 x 4096 bytes.
        enable = 1'b0;
        depth_sel = 4'd15; frame_sel = 4'd15;
        wr_enq(32'h017F_F000);
        wr_deq(32'h0100_0000);
        enable = 1'b1;
        send_msg(1'b0, 32'h017F_F000, 0, "R10 large last frame");
        check("R10 R3 large wrap", enq_ptr, 32'h0100_0000);
        send_msg(1'b1, 32'h0, 0, "R4 large full");

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule